// File: doc/BRIEF.md
# Control-Flow Trace Packet Generator

This block watches the retired control-transfer events of a processor core and turns them into a compact stream of trace packets. Software can later replay the stream against the program image to rebuild the path the core took. Each event carries a branch kind, a taken flag, the address of the transfer instruction and its destination. A level input switches tracing on and off. Opening and closing a trace window each produce a marker packet.

In the normal format, conditional branches are packed as single outcome bits into a bit-group packet. Indirect transfers and returns produce a packet that holds the destination address. Direct transfers produce nothing, because their destinations are fixed in the program image. A mode input selects a reduced format for integrity checking. In that format every indirect transfer and return produces one packet that holds both its source and its destination, and no branch outcome bits are kept.

Packets leave through a valid/ready stream. When the stream stalls, the generator holds its input ready low instead of dropping events. Packet order always matches the order of the events.

Top module: `cftrace_gen`

## Requirements
- R1: After reset no packet is offered (`pktValid` low), the outcome-bit group is empty and tracing is off.
- R2: A rise of `traceEn` emits a start packet (type 1, payload 0). That packet comes before any packet caused by later events, and no event is accepted until it has been issued.
- R3: A fall of `traceEn` first flushes any pending outcome bits as a bit-group packet, then emits a stop packet (type 2, payload 0).
- R4: In normal format each conditional branch (kind 0) appends its taken flag to the bit group. The oldest outcome is at payload bit 0, and payload bits [8:6] hold the number of valid bits. When the sixth bit arrives, a bit-group packet (type 3) with count 6 is emitted.
- R5: In normal format an indirect transfer (kind 2) or a return (kind 3) first flushes any partial bit group as a type 3 packet. It then emits a target packet (type 4) whose payload bits [31:0] hold the destination and whose upper bits are zero.
- R6: A direct transfer (kind 1) emits no packet and leaves the bit group unchanged.
- R7: With `reducedMode` high, an indirect transfer or a return emits one pair packet (type 5) with payload {source, destination}, the source in bits [63:32]. Conditional branches are accepted without adding any outcome bit.
- R8: While `pktReady` is low, an offered packet keeps its type and payload. An event that needs an output slot is held off through `evReady` until it gets one, so no event is lost.
- R9: Events that arrive while tracing is off are accepted and produce no packet, and they leave no outcome bits behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| traceEn | input | 1 | Trace window enable (level) |
| reducedMode | input | 1 | Selects the source/destination pair format |
| evValid | input | 1 | Event offered |
| evReady | output | 1 | Event accepted this cycle |
| evKind | input | 2 | 0 conditional, 1 direct, 2 indirect, 3 return |
| evTaken | input | 1 | Outcome of a conditional branch |
| evSrc | input | 32 | Address of the transfer instruction |
| evDst | input | 32 | Destination address |
| pktValid | output | 1 | Packet offered |
| pktReady | input | 1 | Consumer takes the packet |
| pktType | output | 3 | 1 start, 2 stop, 3 bit group, 4 target, 5 pair |
| pktPayload | output | 64 | Packet payload |

## Verification
A wrong outcome-bit count appears at the very next bit-group or target packet, as a flush with the wrong count, a missing flush or a misplaced bit. The bench therefore closes every branch sequence with an indirect transfer or a window close. A stuck enable state appears within one cycle as a missing start or stop marker, or as events that are never accepted. A corrupted output register appears as a payload that changes during a stall, or as packets out of order once the stall ends.

// File: rtl/cftrace_pkg.sv
package cftrace_pkg;

  typedef enum logic [1:0] {
    BR_COND     = 2'd0,
    BR_DIRECT   = 2'd1,
    BR_INDIRECT = 2'd2,
    BR_RETURN   = 2'd3
  } brKind_e;

  typedef enum logic [2:0] {
    PKT_NONE   = 3'd0,
    PKT_START  = 3'd1,
    PKT_STOP   = 3'd2,
    PKT_BITS   = 3'd3,
    PKT_TARGET = 3'd4,
    PKT_PAIR   = 3'd5
  } pktKind_e;

  // strobes from control to datapath, at most one emit per cycle
  typedef struct packed {
    logic emitStart;
    logic emitStop;
    logic emitBits;
    logic emitTarget;
    logic emitPair;
    logic bitPush;
  } dpCtrl_t;

endpackage

// File: rtl/cftrace_ctrl.sv
module cftrace_ctrl
  import cftrace_pkg::*;
#(
  parameter int TNT_MAX = 6,
  parameter int CW      = $clog2(TNT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          traceEn,
  input  logic          reducedMode,
  input  logic          evValid,
  input  logic [1:0]    evKind,
  input  logic [CW-1:0] bitCnt,
  input  logic          outBusy,
  output logic          evReady,
  output dpCtrl_t       strobes
);

  localparam logic [CW-1:0] LAST_SLOT = CW'(TNT_MAX - 1);

  logic    enState;
  logic    enNext;
  logic    canEmit;
  brKind_e kind;

  assign canEmit = !outBusy;
  assign kind    = brKind_e'(evKind);

  always_comb begin
    strobes = '0;
    evReady = 1'b0;
    enNext  = enState;
    if (traceEn && !enState) begin
      // window opens: marker first, events wait
      if (canEmit) begin
        strobes.emitStart = 1'b1;
        enNext            = 1'b1;
      end
    end else if (!traceEn && enState) begin
      // window closes: flush pending bits, then marker
      if (canEmit) begin
        if (bitCnt != '0) begin
          strobes.emitBits = 1'b1;
        end else begin
          strobes.emitStop = 1'b1;
          enNext           = 1'b0;
        end
      end
    end else if (evValid) begin
      if (!enState) begin
        evReady = 1'b1;
      end else begin
        unique case (kind)
          BR_COND: begin
            if (reducedMode) begin
              evReady = 1'b1;
            end else if (bitCnt == LAST_SLOT) begin
              if (canEmit) begin
                strobes.bitPush  = 1'b1;
                strobes.emitBits = 1'b1;
                evReady          = 1'b1;
              end
            end else begin
              strobes.bitPush = 1'b1;
              evReady         = 1'b1;
            end
          end
          BR_DIRECT: evReady = 1'b1;
          default: begin
            if (canEmit) begin
              if (bitCnt != '0) begin
                strobes.emitBits = 1'b1;
              end else begin
                evReady = 1'b1;
                if (reducedMode) strobes.emitPair   = 1'b1;
                else             strobes.emitTarget = 1'b1;
              end
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) enState <= 1'b0;
    else       enState <= enNext;
  end

  // R2: an opening window is never combined with accepting an event
  a_r2_start_blocks_events: assert property (@(posedge clk) disable iff (!rstN)
    (traceEn && !enState) |-> !evReady);

  // R3: the window only closes through an issued stop packet
  a_r3_close_via_stop: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enState) |-> $past(strobes.emitStop));

endmodule

// File: rtl/cftrace_dp.sv
module cftrace_dp
  import cftrace_pkg::*;
#(
  parameter int AW      = 32,
  parameter int TNT_MAX = 6,
  parameter int CW      = $clog2(TNT_MAX + 1),
  parameter int PW      = 2 * AW
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtrl_t       strobes,
  input  logic          evTaken,
  input  logic [AW-1:0] evSrc,
  input  logic [AW-1:0] evDst,
  input  logic          pktReady,
  output logic [CW-1:0] bitCnt,
  output logic          outBusy,
  output logic          pktValid,
  output logic [2:0]    pktType,
  output logic [PW-1:0] pktPayload
);

  logic [TNT_MAX-1:0] bitReg;
  logic [TNT_MAX-1:0] bitsNext;
  logic [CW-1:0]      cntNext;
  logic               loadOut;
  pktKind_e           loadKind;
  logic [PW-1:0]      loadPayload;

  always_comb begin
    bitsNext = bitReg;
    for (int i = 0; i < TNT_MAX; i++) begin
      if (strobes.bitPush && (bitCnt == CW'(i))) bitsNext[i] = evTaken;
    end
    cntNext = strobes.bitPush ? bitCnt + CW'(1) : bitCnt;
  end

  always_comb begin
    loadOut     = 1'b1;
    loadKind    = PKT_NONE;
    loadPayload = '0;
    if (strobes.emitStart) begin
      loadKind = PKT_START;
    end else if (strobes.emitStop) begin
      loadKind = PKT_STOP;
    end else if (strobes.emitBits) begin
      loadKind                      = PKT_BITS;
      loadPayload[TNT_MAX-1:0]      = bitsNext;
      loadPayload[TNT_MAX +: CW]    = cntNext;
    end else if (strobes.emitTarget) begin
      loadKind           = PKT_TARGET;
      loadPayload[AW-1:0] = evDst;
    end else if (strobes.emitPair) begin
      loadKind    = PKT_PAIR;
      loadPayload = {evSrc, evDst};
    end else begin
      loadOut = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitReg <= '0;
      bitCnt <= '0;
    end else if (strobes.emitBits) begin
      bitReg <= '0;
      bitCnt <= '0;
    end else if (strobes.bitPush) begin
      bitReg <= bitsNext;
      bitCnt <= cntNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktValid   <= 1'b0;
      pktType    <= 3'd0;
      pktPayload <= '0;
    end else if (loadOut) begin
      pktValid   <= 1'b1;
      pktType    <= loadKind;
      pktPayload <= loadPayload;
    end else if (pktReady) begin
      pktValid <= 1'b0;
    end
  end

  assign outBusy = pktValid && !pktReady;

  // R8: a stalled packet holds still
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !pktReady) |=> (pktValid && $stable(pktType) && $stable(pktPayload)));

  // R4: the pending group never reaches the full size without being emitted
  a_r4_group_bounded: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt < CW'(TNT_MAX));

  // R4: a bit-group packet has a count in range and no bits above it
  a_r4_group_wellformed: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && pktType == PKT_BITS) |->
      (pktPayload[TNT_MAX +: CW] != '0) &&
      (pktPayload[TNT_MAX +: CW] <= CW'(TNT_MAX)) &&
      ((pktPayload[TNT_MAX-1:0] >> pktPayload[TNT_MAX +: CW]) == '0));

endmodule

// File: rtl/cftrace_gen.sv
module cftrace_gen
  import cftrace_pkg::*;
#(
  parameter int AW      = 32,
  parameter int TNT_MAX = 6,
  parameter int CW      = $clog2(TNT_MAX + 1),
  parameter int PW      = 2 * AW
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          traceEn,
  input  logic          reducedMode,
  input  logic          evValid,
  output logic          evReady,
  input  logic [1:0]    evKind,
  input  logic          evTaken,
  input  logic [AW-1:0] evSrc,
  input  logic [AW-1:0] evDst,
  output logic          pktValid,
  input  logic          pktReady,
  output logic [2:0]    pktType,
  output logic [PW-1:0] pktPayload
);

  dpCtrl_t       strobes;
  logic [CW-1:0] bitCnt;
  logic          outBusy;

  cftrace_ctrl #(.TNT_MAX(TNT_MAX), .CW(CW)) ctrl_i (
    .clk(clk), .rstN(rstN), .traceEn(traceEn), .reducedMode(reducedMode),
    .evValid(evValid), .evKind(evKind), .bitCnt(bitCnt), .outBusy(outBusy),
    .evReady(evReady), .strobes(strobes)
  );

  cftrace_dp #(.AW(AW), .TNT_MAX(TNT_MAX), .CW(CW), .PW(PW)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .evTaken(evTaken),
    .evSrc(evSrc), .evDst(evDst), .pktReady(pktReady), .bitCnt(bitCnt),
    .outBusy(outBusy), .pktValid(pktValid), .pktType(pktType),
    .pktPayload(pktPayload)
  );

  // R7: reduced-format conditional branches leave the bit group untouched
  a_r7_no_bits_reduced: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && evReady && evKind == 2'd0 && reducedMode) |=> (bitCnt == $past(bitCnt)));

  // R6: direct transfers do not change the bit group
  a_r6_direct_silent: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && evReady && evKind == 2'd1) |=> (bitCnt == $past(bitCnt)));

endmodule

// File: tb/cftrace_gen_tb_top.sv
`timescale 1ns/1ps
module cftrace_gen_tb_top;

  localparam int AW = 32;
  localparam int PW = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          traceEn = 1'b0;
  logic          reducedMode = 1'b0;
  logic          evValid = 1'b0;
  logic          evReady;
  logic [1:0]    evKind = 2'd0;
  logic          evTaken = 1'b0;
  logic [AW-1:0] evSrc = '0;
  logic [AW-1:0] evDst = '0;
  logic          pktValid;
  logic          pktReady = 1'b1;
  logic [2:0]    pktType;
  logic [PW-1:0] pktPayload;

  int checks = 0;
  int failures = 0;

  logic [2:0]    capType [0:63];
  logic [PW-1:0] capPay  [0:63];
  int            capN = 0;

  always #4 clk = ~clk;

  cftrace_gen dut_i (
    .clk(clk), .rstN(rstN), .traceEn(traceEn), .reducedMode(reducedMode),
    .evValid(evValid), .evReady(evReady), .evKind(evKind), .evTaken(evTaken),
    .evSrc(evSrc), .evDst(evDst), .pktValid(pktValid), .pktReady(pktReady),
    .pktType(pktType), .pktPayload(pktPayload)
  );

  always @(negedge clk) begin
    if (rstN && pktValid && pktReady && capN < 64) begin
      capType[capN] = pktType;
      capPay[capN]  = pktPayload;
      capN++;
    end
  end

  function automatic logic [PW-1:0] grp(input int cnt, input logic [5:0] bits);
    logic [PW-1:0] p = '0;
    p[5:0] = bits;
    p[8:6] = 3'(cnt);
    return p;
  endfunction

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expPkt(input string req, input int idx, input logic [2:0] t, input logic [PW-1:0] p);
    check({req, " count"}, 64'(capN > idx), 64'd1);
    if (capN > idx) begin
      check({req, " type"}, 64'(capType[idx]), 64'(t));
      check({req, " payload"}, capPay[idx], p);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sendEv(input logic [1:0] k, input logic tk, input logic [AW-1:0] s, input logic [AW-1:0] d);
    logic acc;
    evValid = 1'b1; evKind = k; evTaken = tk; evSrc = s; evDst = d;
    do begin
      @(negedge clk); acc = evReady;
      @(posedge clk); #1;
    end while (!acc);
    evValid = 1'b0;
  endtask

  task automatic setEn(input logic v);
    traceEn = v;
    step(4);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 no packet after reset", 64'(pktValid), 64'd0);
  endtask

  task automatic t_enable();
    capN = 0;
    setEn(1'b1);
    check("R2 one start packet", 64'(capN), 64'd1);
    expPkt("R2 start", 0, 3'd1, '0);
  endtask

  task automatic t_direct();
    capN = 0;
    sendEv(2'd1, 1'b0, 32'h10, 32'h20);
    step(3);
    check("R6 direct emits nothing", 64'(capN), 64'd0);
  endtask

  task automatic t_full_group();
    capN = 0;
    sendEv(2'd0, 1'b1, '0, '0);
    sendEv(2'd0, 1'b0, '0, '0);
    sendEv(2'd0, 1'b1, '0, '0);
    sendEv(2'd0, 1'b1, '0, '0);
    sendEv(2'd0, 1'b0, '0, '0);
    check("R4 no packet before sixth bit", 64'(capN), 64'd0);
    sendEv(2'd0, 1'b0, '0, '0);
    step(2);
    check("R4 one group packet", 64'(capN), 64'd1);
    expPkt("R4 full group", 0, 3'd3, grp(6, 6'b001101));
  endtask

  task automatic t_partial_then_target();
    capN = 0;
    sendEv(2'd0, 1'b1, '0, '0);
    sendEv(2'd0, 1'b1, '0, '0);
    sendEv(2'd0, 1'b0, '0, '0);
    sendEv(2'd2, 1'b0, 32'h500, 32'h1000);
    sendEv(2'd3, 1'b0, 32'h600, 32'h2222);
    step(2);
    check("R5 packet count", 64'(capN), 64'd3);
    expPkt("R5 flush before target", 0, 3'd3, grp(3, 6'b000011));
    expPkt("R5 indirect target", 1, 3'd4, 64'h1000);
    expPkt("R5 return target", 2, 3'd4, 64'h2222);
  endtask

  task automatic t_reduced();
    capN = 0;
    reducedMode = 1'b1;
    sendEv(2'd0, 1'b1, '0, '0);
    sendEv(2'd0, 1'b0, '0, '0);
    sendEv(2'd2, 1'b0, 32'hAAAA, 32'hBBBB);
    sendEv(2'd3, 1'b0, 32'hCCCC, 32'hDDDD);
    step(2);
    check("R7 only pair packets", 64'(capN), 64'd2);
    expPkt("R7 indirect pair", 0, 3'd5, {32'hAAAA, 32'hBBBB});
    expPkt("R7 return pair", 1, 3'd5, {32'hCCCC, 32'hDDDD});
    reducedMode = 1'b0;
  endtask

  task automatic t_stall();
    capN = 0;
    pktReady = 1'b0;
    fork
      begin
        sendEv(2'd2, 1'b0, 32'h1, 32'hA0);
        sendEv(2'd2, 1'b0, 32'h2, 32'hB0);
      end
    join_none
    repeat (6) @(negedge clk);
    check("R8 packet offered during stall", 64'(pktValid), 64'd1);
    check("R8 stalled payload held", pktPayload, 64'hA0);
    check("R8 second event held off", 64'(evReady), 64'd0);
    step(1);
    pktReady = 1'b1;
    step(5);
    check("R8 both delivered", 64'(capN), 64'd2);
    expPkt("R8 first", 0, 3'd4, 64'hA0);
    expPkt("R8 second", 1, 3'd4, 64'hB0);
  endtask

  task automatic t_disable();
    capN = 0;
    sendEv(2'd0, 1'b1, '0, '0);
    sendEv(2'd0, 1'b0, '0, '0);
    setEn(1'b0);
    check("R3 two packets on close", 64'(capN), 64'd2);
    expPkt("R3 flush on close", 0, 3'd3, grp(2, 6'b000001));
    expPkt("R3 stop", 1, 3'd2, '0);
  endtask

  task automatic t_off_events();
    capN = 0;
    sendEv(2'd2, 1'b0, 32'h7, 32'h8);
    sendEv(2'd0, 1'b1, '0, '0);
    sendEv(2'd0, 1'b1, '0, '0);
    step(2);
    check("R9 no packet while off", 64'(capN), 64'd0);
    setEn(1'b1);
    capN = 0;
    sendEv(2'd0, 1'b1, '0, '0);
    sendEv(2'd2, 1'b0, 32'h9, 32'h4444);
    step(2);
    expPkt("R9 no leftover bits", 0, 3'd3, grp(1, 6'b000001));
    expPkt("R9 target after reopen", 1, 3'd4, 64'h4444);
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    t_reset();
    step(1);
    t_enable();
    t_direct();
    t_full_group();
    t_partial_then_target();
    t_reduced();
    t_stall();
    t_disable();
    t_off_events();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule